// File: doc/BRIEF.md
# SPI Host Port with Word-Request Handshake

This block is a 24-bit serial host port that works either as an SPI master or as an SPI slave. It uses SPI mode 0 and shifts the most significant bit first. Both roles add an active-low request line that paces the transfer one word at a time. As a slave, the port pulls the request line low once it holds a word ready to send. As a master, it clocks out a word only after the far end has pulled that line low, and after each word it stops to wait for the line again.

On the system side, transmit words enter a one-word buffer through a valid/ready handshake. Each received word appears on `rx_data` together with a one-cycle `rx_valid` pulse. In master mode, SCK comes from a programmable divider of the system clock. In slave mode, SCK, MOSI, slave select and the request input each pass through a two-stage synchronizer, and SCK edges are detected on the synchronized copies. If slave select is seen active while the port is configured as master, the port raises a sticky bus-error flag. A dedicated clear strobe or reset removes it.

Top module: `spi_hreq_port`

## Requirements
- R1: While `rst_n` is low, `sck_oe`, `mosi_oe`, `miso_oe` and `req_n_oe` are 0, `bus_err` is 0 and `tx_ready` is 1. One cycle after any clock edge that sees reset, all four enables are 0.
- R2: In master mode a word is 24 bits, most significant bit first. `mosi_out` changes only on falling SCK edges. `miso_in` is sampled on each rising SCK edge. The received word appears on `rx_data` with `rx_valid` high for one cycle, at the clock edge of the 24th falling SCK edge.
- R3: In master mode each SCK phase, high or low, lasts `clk_div`+1 system clock cycles. `sck_out` is 0 between words.
- R4: The master begins a word only while the synchronized `req_n_in` is 0 and a transmit word is buffered. After each word it returns to idle with SCK low and starts nothing more while `req_n_in` is 1.
- R5: In slave mode (`cfg_master`=0) the port samples `mosi_in` on rising edges of `sck_in`. It presents its buffered word on `miso_out`, most significant bit first, and shifts on falling edges. After the 24th falling edge, `rx_data` carries the received word with a one-cycle `rx_valid`.
- R6: In slave mode, while `ss_n_in` is 1, SCK edges have no effect: the bit position does not advance and no word completes. `miso_oe` is 0 in this state.
- R7: In slave mode with any request-enable bit set, `req_n_oe` is 1. `req_n_out` goes to 0 once a transmit word is loaded into the shifter, and returns to 1 on the first rising SCK edge of the word.
- R8: `req_n_oe` is 0 when `cfg_req_en` is 2'b00 and whenever the port is in master mode.
- R9: A 0 on the synchronized `ss_n_in` while the port is enabled as master sets `bus_err`. The flag stays 1 until `err_clr` is pulsed. A 0 on `ss_n_in` in slave mode does not set it.
- R10: `tx_ready` is 1 exactly when the one-word transmit buffer is empty. It goes to 0 after a word is accepted and returns to 1 once that word moves into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_master | input | 1 | 1 = master, 0 = slave |
| cfg_req_en | input | 2 | Request-line enables; 2'b00 keeps the line undriven |
| clk_div | input | 8 | SCK half-period minus one, in system clocks |
| err_clr | input | 1 | Clear strobe for the bus-error flag |
| tx_data | input | 24 | Transmit word |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit buffer empty |
| rx_data | output | 24 | Last received word |
| rx_valid | output | 1 | One-cycle pulse with each received word |
| bus_err | output | 1 | Sticky bus-error flag |
| sck_in | input | 1 | Serial clock from a remote master |
| sck_out | output | 1 | Serial clock driven as master |
| sck_oe | output | 1 | Drive enable for sck_out |
| mosi_in | input | 1 | Serial data into the slave |
| mosi_out | output | 1 | Serial data out of the master |
| mosi_oe | output | 1 | Drive enable for mosi_out |
| miso_in | input | 1 | Serial data into the master |
| miso_out | output | 1 | Serial data out of the slave |
| miso_oe | output | 1 | Drive enable for miso_out |
| ss_n_in | input | 1 | Active-low slave select |
| req_n_in | input | 1 | Active-low request from a remote slave |
| req_n_out | output | 1 | Active-low request to a remote master |
| req_n_oe | output | 1 | Drive enable for req_n_out |

## Verification
In master mode, SCK edges, MOSI changes and the `rx_valid` pulse are all registered at the same clock edge as the divider tick. The bench observes each of them on the following falling clock edge and counts exactly `clk_div`+1 cycles between SCK transitions. The start of a word depends on a two-flop synchronizer, so the bench times no edge against its own request change; it only checks that SCK stays low while the request is high. Slave-side results come about three clocks after the pin edge that causes them: two synchronizer stages plus the state register. The bench therefore holds each SCK phase for at least four cycles and samples MISO, the request line and the received word only at the end of a phase.

// File: rtl/spi_hreq_pkg.sv
// Shared types for the SPI host port.
// Assumes: a single FSM serves both roles, selected by the mode input.
package spi_hreq_pkg;

    // Port state: idle, slave armed (word loaded, request low),
    // master SCK low/high phases, slave word in progress.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_LOW   = 3'd2,
        ST_HIGH  = 3'd3,
        ST_SBUSY = 3'd4
    } port_state_e;

endpackage

// File: rtl/spi_hreq_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes: each bit is an independent level; reset value is per bit.
module spi_hreq_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the sample one stage further from the pin.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[i] <= RST_VAL;
                end else if (i == 0) begin
                    stg[i] <= d;
                end else begin
                    stg[i] <= stg[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_hreq_sckgen.sv
// Divider that times the master SCK phases.
// Assumes: tick fires on the last cycle of each phase; the count restarts
// whenever run is low, so the first phase after a start is full length.
module spi_hreq_sckgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // Count system clocks within the current SCK phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_hreq_txbuf.sv
// One-word transmit holding buffer with a valid/ready input side.
// Assumes: take is only raised while full is set.
module spi_hreq_txbuf #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              take,
    output logic              full,
    output logic [WORD_W-1:0] data
);

    assign in_ready = !full;

    // Hold one word from acceptance until the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            data <= in_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // An accepted word blocks further input on the next cycle.
    assert_accept_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

endmodule

// File: rtl/spi_hreq_port.sv
// SPI master/slave host port with a per-word active-low request handshake.
// Assumes: SPI mode 0, MSB first; slave-side pins are asynchronous and are
// synchronized here; the request line is active low in both directions.
module spi_hreq_port #(
    parameter int WORD_W = 24,
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_master,
    input  logic [1:0]        cfg_req_en,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              err_clr,
    input  logic [WORD_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic [WORD_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              bus_err,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              mosi_in,
    output logic              mosi_out,
    output logic              mosi_oe,
    input  logic              miso_in,
    output logic              miso_out,
    output logic              miso_oe,
    input  logic              ss_n_in,
    input  logic              req_n_in,
    output logic              req_n_out,
    output logic              req_n_oe
);
    import spi_hreq_pkg::*;

    localparam int               CNT_W    = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    port_state_e       state;
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] sh_next;
    logic              cap;
    logic [CNT_W-1:0]  bit_cnt;
    logic              sck_q;
    logic              sck_prev;
    logic [3:0]        sync_q;
    logic              sck_s, mosi_s, ss_s, req_s;
    logic              s_rise, s_fall;
    logic              run_m, run_s, s_sel;
    logic              tick, div_run;
    logic              tx_full, take;
    logic [WORD_W-1:0] tx_word;
    logic              last_bit;

    // Pin synchronizers: idle values are SCK low, MOSI low, SS high, request high.
    spi_hreq_sync #(.WIDTH(4), .STAGES(SYNC_N), .RST_VAL(4'b0011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_in, mosi_in, ss_n_in, req_n_in}),
        .q     (sync_q)
    );
    assign {sck_s, mosi_s, ss_s, req_s} = sync_q;

    assign run_m   = cfg_en && cfg_master;
    assign run_s   = cfg_en && !cfg_master;
    assign s_sel   = run_s && !ss_s;
    assign s_rise  = sck_s && !sck_prev;
    assign s_fall  = !sck_s && sck_prev;
    assign div_run = (state == ST_LOW) || (state == ST_HIGH);
    assign sh_next = {shreg[WORD_W-2:0], cap};
    assign last_bit = (bit_cnt == LAST_BIT);

    spi_hreq_sckgen #(.DIV_W(DIV_W)) u_sckgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (div_run),
        .div   (clk_div),
        .tick  (tick)
    );

    spi_hreq_txbuf #(.WORD_W(WORD_W)) u_txbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .take     (take),
        .full     (tx_full),
        .data     (tx_word)
    );

    // Decide when the idle shifter pulls the buffered word.
    always_comb begin
        take = 1'b0;
        if (state == ST_IDLE && tx_full) begin
            take = (run_m && !req_s) || run_s;
        end
    end

    // Remember the previous synchronized SCK level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    // Main port FSM: master phase timing and slave edge handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cap      <= 1'b0;
            bit_cnt  <= '0;
            sck_q    <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    sck_q   <= 1'b0;
                    if (take && run_m) begin
                        shreg <= tx_word;
                        state <= ST_LOW;
                    end else if (take) begin
                        shreg <= tx_word;
                        state <= ST_ARMED;
                    end else if (s_sel && s_rise) begin
                        cap   <= mosi_s;
                        state <= ST_SBUSY;
                    end
                end
                ST_ARMED: begin
                    if (!run_s) begin
                        state <= ST_IDLE;
                    end else if (s_sel && s_rise) begin
                        cap   <= mosi_s;
                        state <= ST_SBUSY;
                    end
                end
                ST_LOW: begin
                    if (!run_m) begin
                        state <= ST_IDLE;
                    end else if (tick) begin
                        sck_q <= 1'b1;
                        cap   <= miso_in;
                        state <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (!run_m) begin
                        sck_q <= 1'b0;
                        state <= ST_IDLE;
                    end else if (tick) begin
                        sck_q <= 1'b0;
                        if (last_bit) begin
                            rx_data  <= sh_next;
                            rx_valid <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            shreg   <= sh_next;
                            bit_cnt <= bit_cnt + 1'b1;
                            state   <= ST_LOW;
                        end
                    end
                end
                ST_SBUSY: begin
                    if (!s_sel) begin
                        state <= ST_IDLE;
                    end else if (s_rise) begin
                        cap <= mosi_s;
                    end else if (s_fall) begin
                        if (last_bit) begin
                            rx_data  <= sh_next;
                            rx_valid <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            shreg   <= sh_next;
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Register the pin drive enables so reset and mode changes settle cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_oe   <= 1'b0;
            mosi_oe  <= 1'b0;
            miso_oe  <= 1'b0;
            req_n_oe <= 1'b0;
        end else begin
            sck_oe   <= run_m;
            mosi_oe  <= run_m;
            miso_oe  <= s_sel;
            req_n_oe <= run_s && (cfg_req_en != 2'b00);
        end
    end

    // Sticky bus-error flag: a set outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bus_err <= 1'b0;
        else if (run_m && !ss_s)    bus_err <= 1'b1;
        else if (err_clr)           bus_err <= 1'b0;
    end

    assign sck_out   = sck_q;
    assign mosi_out  = shreg[WORD_W-1];
    assign miso_out  = shreg[WORD_W-1];
    assign req_n_out = (state != ST_ARMED);

    // R1: reset leaves every pin undriven on the next cycle.
    assert_reset_undriven_R1: assert property (@(posedge clk)
        !rst_n |=> (!sck_oe && !mosi_oe && !miso_oe && !req_n_oe));

    // R4: a master word only begins after a low request was seen.
    assert_master_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOW && $past(state) == ST_IDLE) |-> !$past(req_s));

    // R6: a deselected slave does not drive MISO.
    assert_miso_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ss_s) |-> !miso_oe);

    // R7: the first SCK rise of a word releases the request.
    assert_req_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && s_sel && s_rise) |=> req_n_out);

    // R9: the error flag only drops with a clear strobe.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !err_clr) |=> bus_err);

endmodule

// File: tb/spi_hreq_port_test.sv
module spi_hreq_port_test;
    localparam int W  = 24;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b1, cfg_master = 1'b1;
    logic [1:0]    cfg_req_en = 2'b01;
    logic [DW-1:0] clk_div = '0;
    logic          err_clr = 1'b0;
    logic [W-1:0]  tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic [W-1:0]  rx_data;
    logic          rx_valid, bus_err;
    logic          sck_in = 1'b0, sck_out, sck_oe;
    logic          mosi_in = 1'b0, mosi_out, mosi_oe;
    logic          miso_in = 1'b0, miso_out, miso_oe;
    logic          ss_n_in = 1'b1, req_n_in = 1'b1, req_n_out, req_n_oe;

    spi_hreq_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_master(cfg_master),
        .cfg_req_en(cfg_req_en), .clk_div(clk_div), .err_clr(err_clr),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .bus_err(bus_err),
        .sck_in(sck_in), .sck_out(sck_out), .sck_oe(sck_oe),
        .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe),
        .miso_in(miso_in), .miso_out(miso_out), .miso_oe(miso_oe),
        .ss_n_in(ss_n_in), .req_n_in(req_n_in), .req_n_out(req_n_out),
        .req_n_oe(req_n_oe)
    );

    int total = 0;
    int bad = 0;
    int rx_cnt = 0;
    logic [W-1:0] rx_last = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp_v);
        end
    endtask

    // Received-word monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt++;
            rx_last = rx_data;
        end
    end

    function automatic logic [W-1:0] pat(input int k);
        logic [31:0] t;
        t = k * 32'h9E3779B1 + 32'h01234567;
        return t[27:4];
    endfunction

    task automatic load_tx(input logic [W-1:0] w);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        tx_data  = w;
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // Master word: the bench acts as the remote slave.
    task automatic master_word(input logic [W-1:0] txw, input logic [W-1:0] swd,
                               input int div);
        int rises = 0, falls = 0, cnt = 0, badhp = 0, guard = 0, rx0;
        bit prev = 1'b0, quiet = 1'b1;
        logic [W-1:0] got = '0;
        load_tx(txw);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sck_out) quiet = 1'b0;
        end
        chk(quiet, "R4 no SCK while request high", 32'(!quiet), 0);
        chk(tx_ready == 1'b0, "R10 buffer held while waiting", 32'(tx_ready), 0);
        rx0 = rx_cnt;
        miso_in  = swd[W-1];
        req_n_in = 1'b0;
        while (falls < W && guard < 5000) begin
            @(negedge clk);
            guard++;
            cnt++;
            if (sck_out && !prev) begin
                got = {got[W-2:0], mosi_out};
                if (rises > 0 && cnt != div + 1) badhp++;
                rises++;
                cnt = 0;
                if (rises == 1) req_n_in = 1'b1;
            end else if (!sck_out && prev) begin
                if (cnt != div + 1) badhp++;
                falls++;
                cnt = 0;
                if (falls < W) miso_in = swd[W-1-falls];
            end
            prev = sck_out;
        end
        repeat (3) @(negedge clk);
        chk(got == txw, "R2 master MOSI word", 32'(got), 32'(txw));
        chk(rx_cnt == rx0 + 1 && rx_last == swd, "R2 master received word",
            32'(rx_last), 32'(swd));
        chk(badhp == 0, "R3 SCK phase length", badhp, 0);
        chk(sck_out == 1'b0, "R3 SCK idles low", 32'(sck_out), 0);
    endtask

    // Slave word: the bench acts as the remote master.
    task automatic slave_word(input logic [W-1:0] mw, input logic [W-1:0] exw,
                              input int h);
        logic [W-1:0] got = '0;
        int rx0;
        rx0 = rx_cnt;
        sck_in  = 1'b0;
        ss_n_in = 1'b0;
        repeat (4) @(negedge clk);
        chk(miso_oe == 1'b1, "R6 MISO driven when selected", 32'(miso_oe), 1);
        chk(req_n_out == 1'b0 && req_n_oe == 1'b1, "R7 request low when armed",
            32'({req_n_oe, req_n_out}), 32'h2);
        for (int i = 0; i < W; i++) begin
            mosi_in = mw[W-1-i];
            repeat (h) @(negedge clk);
            got = {got[W-2:0], miso_out};
            sck_in = 1'b1;
            repeat (h) @(negedge clk);
            if (i == 0) chk(req_n_out == 1'b1, "R7 request released on first rise",
                            32'(req_n_out), 1);
            sck_in = 1'b0;
        end
        repeat (h) @(negedge clk);
        chk(rx_cnt == rx0 + 1 && rx_last == mw, "R5 slave received word",
            32'(rx_last), 32'(mw));
        chk(got == exw, "R5 slave MISO word", 32'(got), 32'(exw));
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int rx0;
        bit quiet;
        repeat (5) @(negedge clk);
        // R1: reset state of the pins, flag and buffer.
        chk({sck_oe, mosi_oe, miso_oe, req_n_oe} == 4'b0, "R1 enables off in reset",
            32'({sck_oe, mosi_oe, miso_oe, req_n_oe}), 0);
        chk(bus_err == 1'b0 && tx_ready == 1'b1, "R1 flag clear, buffer empty",
            32'({bus_err, tx_ready}), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(req_n_oe == 1'b0 && mosi_oe == 1'b1, "R8 request undriven as master",
            32'({req_n_oe, mosi_oe}), 1);

        // Master sweep over divider settings and word patterns.
        for (int d = 0; d < 4; d++) begin
            clk_div = DW'(d);
            for (int k = 0; k < 3; k++) begin
                logic [W-1:0] a, b;
                a = (k == 0) ? 24'h800001 : pat(d * 7 + k);
                b = (k == 1) ? 24'hFFFFFF : pat(d * 11 + k + 40);
                master_word(a, b, d);
            end
        end

        // R9: slave select in master mode raises a sticky error.
        ss_n_in = 1'b0;
        repeat (5) @(negedge clk);
        ss_n_in = 1'b1;
        repeat (5) @(negedge clk);
        chk(bus_err == 1'b1, "R9 error set by select in master", 32'(bus_err), 1);
        repeat (10) @(negedge clk);
        chk(bus_err == 1'b1, "R9 error stays set", 32'(bus_err), 1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        @(negedge clk);
        chk(bus_err == 1'b0, "R9 error cleared by strobe", 32'(bus_err), 0);

        // Slave mode: select does not raise the error.
        cfg_master = 1'b0;
        repeat (3) @(negedge clk);
        ss_n_in = 1'b0;
        repeat (6) @(negedge clk);
        ss_n_in = 1'b1;
        repeat (4) @(negedge clk);
        chk(bus_err == 1'b0, "R9 no error in slave mode", 32'(bus_err), 0);

        // R10: an armed word frees the buffer, a second word fills it.
        load_tx(24'hA5C30F);
        repeat (3) @(negedge clk);
        chk(tx_ready == 1'b1 && req_n_out == 1'b0, "R10 buffer freed when armed",
            32'({tx_ready, req_n_out}), 32'h2);
        load_tx(24'h123456);
        @(negedge clk);
        chk(tx_ready == 1'b0, "R10 buffer full behind armed word", 32'(tx_ready), 0);
        slave_word(24'h0F0F0F, 24'hA5C30F, 6);
        slave_word(24'h000000, 24'h123456, 6);

        // R6: SCK edges while deselected are ignored.
        load_tx(24'h5AA5C3);
        repeat (3) @(negedge clk);
        rx0 = rx_cnt;
        quiet = 1'b1;
        for (int i = 0; i < 30; i++) begin
            mosi_in = i[0];
            sck_in = 1'b1;
            repeat (4) @(negedge clk);
            sck_in = 1'b0;
            repeat (4) @(negedge clk);
            if (miso_oe) quiet = 1'b0;
        end
        chk(quiet && rx_cnt == rx0, "R6 deselected edges ignored",
            32'(rx_cnt - rx0), 0);
        chk(req_n_out == 1'b0, "R6 still armed after ignored edges", 32'(req_n_out), 0);
        slave_word(24'hC0FFEE, 24'h5AA5C3, 5);

        // Slave sweep over phase lengths and patterns.
        for (int h = 4; h < 10; h += 2) begin
            for (int k = 0; k < 3; k++) begin
                logic [W-1:0] a, b;
                a = pat(h * 5 + k + 90);
                b = (k == 2) ? 24'h800001 : pat(h * 3 + k + 200);
                load_tx(a);
                slave_word(b, a, h);
            end
        end

        // R8: request line undriven with both enable bits cleared.
        cfg_req_en = 2'b00;
        repeat (3) @(negedge clk);
        chk(req_n_oe == 1'b0, "R8 request undriven with enables clear",
            32'(req_n_oe), 0);
        cfg_req_en = 2'b10;
        repeat (3) @(negedge clk);
        chk(req_n_oe == 1'b1, "R7 request driven with one enable bit",
            32'(req_n_oe), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule